// File: doc/BRIEF.md
# Accumulative hash padding detector

This block sits in front of a hash core that takes a message in several requests. Software sends the message as a run of segments and pre-pads only the final one. For each request the block adds the request length to a running byte total. It then decides whether this request is where the message really ends. The decision has three steps. The last eight bytes of the request are read as a big-endian bit count. That count is checked against the running total. The block then reads one byte of the request, at the offset the check yields, and looks for the 0x80 marker that opens standard hash padding.

A request that does not end the message is stored as a segment length in a small cache. A request that does end it releases the whole group. The block pulses a completion strobe, reports the trimmed length of the final piece (its bytes up to, not including, the padding) and reports how many segments make up the message. The cached lengths stay readable by index until the next request arrives. The byte sample is taken through a combinational read port: the block drives a byte offset, and the surrounding logic returns that byte of the current request in the same cycle.

Top module: `acc_pad_detect`

## Requirements
- R1: After reset, seg_count and run_total are 0 and done and err are low.
- R2: A request that does not end the message stores req_len at cache index seg_count, raises seg_count by 1 and adds req_len to run_total. The stored length is readable on cache_len by driving cache_sel with that index.
- R3: The message byte length is the 64-bit req_tail divided by 8, low three bits dropped. req_tail[63:56] holds the first of the eight tail bytes, so the count is read big-endian. Padding is considered only when this length is at most run_total + req_len.
- R4: The padding size is (run_total + req_len) minus the message length. The pad offset is req_len minus the padding size, and it is driven on rd_addr in the same cycle as req_valid. Padding is considered only when the padding size is between 1 and req_len.
- R5: Padding is confirmed only when rd_data equals 8'h80. A request whose length fields match but whose marker byte differs is cached like any other.
- R6: On confirmed padding, done is high for exactly the next cycle. final_len holds the pad offset. done_segs holds the number of cached segments plus one for the final piece. seg_count and run_total return to 0.
- R7: When the pad offset is 0, the final piece is empty and is not counted in done_segs, and final_len is 0.
- R8: The cache holds DEPTH (16) segments. A request that must be cached while the cache is full raises err for one cycle, is not stored, and clears seg_count and run_total.
- R9: Cycles with req_valid low leave seg_count, run_total and the cached lengths unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | One request is presented this cycle |
| req_len | input | LEN_W (28) | Byte length of the request |
| req_tail | input | 64 | Last eight bytes of the request, first byte in bits 63:56 |
| rd_addr | output | LEN_W (28) | Byte offset within the request to sample |
| rd_data | input | 8 | Byte of the request at rd_addr, same cycle |
| cache_sel | input | $clog2(DEPTH) | Index of a cached segment to read |
| cache_len | output | LEN_W (28) | Cached length at cache_sel |
| seg_count | output | $clog2(DEPTH+2) | Segments currently cached |
| run_total | output | TOT_W (32) | Running byte total of the open group |
| done | output | 1 | One-cycle strobe: message end found |
| done_segs | output | $clog2(DEPTH+2) | Segments in the released message |
| final_len | output | LEN_W (28) | Trimmed length of the final piece |
| err | output | 1 | One-cycle strobe: cache overflow, group dropped |

## Verification
A wrong running total or segment count shows up on seg_count and run_total in the cycle after the request that corrupted it. It also shows on rd_addr during the next request, because the pad offset is derived from the total. A missed or false padding hit is visible one cycle after the request: done either stays low or pulses with a final_len and done_segs that disagree with the lengths the bench sent. The directed tests walk single-request messages, multi-request messages, a marker mismatch, an empty final piece, padding that would reach back into an earlier segment, a byte-swapped length and a full cache, and check each result at the first cycle it can appear.

// File: rtl/acc_pad_detect.sv
module acc_pad_detect #(
  parameter int LEN_W = 28,
  parameter int TOT_W = 32,
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [LEN_W-1:0] req_len,
  input  logic [63:0]      req_tail,
  output logic [LEN_W-1:0] rd_addr,
  input  logic [7:0]       rd_data,
  input  logic [IDX_W-1:0] cache_sel,
  output logic [LEN_W-1:0] cache_len,
  output logic [CW-1:0]    seg_count,
  output logic [TOT_W-1:0] run_total,
  output logic             done,
  output logic [CW-1:0]    done_segs,
  output logic [LEN_W-1:0] final_len,
  output logic             err
);

  logic [LEN_W-1:0] cache [DEPTH];
  logic [CW-1:0]    cnt;
  logic [TOT_W-1:0] total;

  logic [TOT_W-1:0] sum;
  logic [60:0]      msg_len;
  logic [TOT_W-1:0] pad_sz;
  logic             fits, in_req, hit, full;
  logic [LEN_W-1:0] pad_off;

  assign sum     = total + TOT_W'(req_len);
  assign msg_len = req_tail[63:3];
  assign fits    = msg_len <= 61'(sum);
  assign pad_sz  = sum - msg_len[TOT_W-1:0];
  assign in_req  = (pad_sz != '0) && (pad_sz <= TOT_W'(req_len));
  assign pad_off = req_len - pad_sz[LEN_W-1:0];
  assign hit     = req_valid && fits && in_req && (rd_data == 8'h80);
  assign full    = cnt == CW'(DEPTH);

  assign rd_addr   = pad_off;
  assign cache_len = cache[cache_sel];
  assign seg_count = cnt;
  assign run_total = total;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      total     <= '0;
      done      <= 1'b0;
      err       <= 1'b0;
      done_segs <= '0;
      final_len <= '0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      if (hit) begin
        done      <= 1'b1;
        done_segs <= cnt + CW'(pad_off != '0);
        final_len <= pad_off;
        cnt       <= '0;
        total     <= '0;
      end else if (req_valid && full) begin
        err   <= 1'b1;
        cnt   <= '0;
        total <= '0;
      end else if (req_valid) begin
        cnt   <= cnt + 1'b1;
        total <= sum;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (req_valid && !hit && !full)
      cache[cnt[IDX_W-1:0]] <= req_len;
  end

endmodule

// File: rtl/acc_pad_detect_chk.sv
module acc_pad_detect_chk #(
  parameter int TOT_W = 32,
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [CW-1:0]    seg_count,
  input logic [TOT_W-1:0] run_total,
  input logic             done,
  input logic             err
);

  // R1
  no_strobe_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!done && !err && seg_count == '0 && run_total == '0));

  // R6
  done_clears_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (seg_count == '0 && run_total == '0));

  // R6
  done_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !$past(req_valid)) |=> !done);

  // R8
  err_clears_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (seg_count == '0 && run_total == '0));

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seg_count <= CW'(DEPTH));

  // R6 R8
  single_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));

  // R9
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(seg_count) && $stable(run_total) && !done && !err));

endmodule

bind acc_pad_detect acc_pad_detect_chk #(.TOT_W(TOT_W), .DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .seg_count(seg_count),
  .run_total(run_total), .done(done), .err(err)
);

// File: tb/acc_pad_detect_bench.sv
`timescale 1ns/100ps
module acc_pad_detect_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [27:0] req_len = '0;
  logic [63:0] req_tail = '0;
  logic [27:0] rd_addr;
  logic [7:0]  rd_data;
  logic [3:0]  cache_sel = '0;
  logic [27:0] cache_len;
  logic [4:0]  seg_count, done_segs;
  logic [31:0] run_total;
  logic        done, err;
  logic [27:0] final_len;
  logic [7:0]  buff [256];
  int checks = 0, errors = 0, cycles = 0;
  localparam logic [63:0] NOPAD = 64'hFFFF_FFFF_FFFF_FFF8;

  always #2.5 clk = ~clk;
  assign rd_data = buff[rd_addr[7:0]];

  acc_pad_detect u_acc_pad_detect (.*);

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++; checks++;
      $display("FAIL watchdog: act %0d exp below 20000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act %0h exp %0h", tag, act, exp);
    end
  endtask

  task automatic fill(int marker_at, logic [7:0] marker);
    for (int i = 0; i < 256; i++) buff[i] = 8'h00;
    if (marker_at >= 0) buff[marker_at] = marker;
  endtask

  task automatic send(int len, logic [63:0] tail, output logic [27:0] addr_seen);
    @(negedge clk);
    req_valid = 1'b1; req_len = 28'(len); req_tail = tail;
    #1 addr_seen = rd_addr;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 seg_count", seg_count, 0);
    chk("R1 run_total", run_total, 0);
    chk("R1 done", done, 0);
    chk("R1 err", err, 0);
  endtask

  task automatic t_single();
    logic [27:0] a;
    do_reset();
    fill(55, 8'h80);
    send(64, 64'd440, a);
    chk("R4 rd_addr", a, 55);
    chk("R6 done", done, 1);
    chk("R6 final_len", final_len, 55);
    chk("R6 done_segs", done_segs, 1);
    chk("R6 run_total cleared", run_total, 0);
    @(negedge clk);
    chk("R6 done pulse", done, 0);
  endtask

  task automatic t_multi();
    logic [27:0] a;
    do_reset();
    fill(-1, 0);
    send(64, NOPAD, a);
    send(48, NOPAD, a);
    chk("R2 seg_count", seg_count, 2);
    chk("R2 run_total", run_total, 112);
    cache_sel = 4'd1; #1;
    chk("R2 cache_len[1]", cache_len, 48);
    repeat (3) @(negedge clk);
    chk("R9 idle seg_count", seg_count, 2);
    chk("R9 idle run_total", run_total, 112);
    // msg 152: sum 176, pad 24, offset 40
    fill(40, 8'h80);
    send(64, 64'd1216, a);
    chk("R4 rd_addr multi", a, 40);
    chk("R6 done multi", done, 1);
    chk("R6 final_len multi", final_len, 40);
    chk("R6 done_segs multi", done_segs, 3);
    cache_sel = 4'd0; #1;
    chk("R2 cache_len[0] kept", cache_len, 64);
  endtask

  task automatic t_marker();
    logic [27:0] a;
    do_reset();
    fill(55, 8'h81);
    send(64, 64'd440, a);
    chk("R5 no done", done, 0);
    chk("R5 cached", seg_count, 1);
    chk("R5 total", run_total, 64);
  endtask

  task automatic t_big_endian();
    logic [27:0] a;
    do_reset();
    fill(55, 8'h80);
    send(64, 64'hB801_0000_0000_0000, a);
    chk("R3 swapped no done", done, 0);
    chk("R3 swapped cached", seg_count, 1);
  endtask

  task automatic t_too_long();
    logic [27:0] a;
    do_reset();
    fill(0, 8'h80);
    send(32, 64'd264, a);
    chk("R3 msg beyond total no done", done, 0);
    chk("R3 msg beyond total cached", seg_count, 1);
  endtask

  task automatic t_empty_final();
    logic [27:0] a;
    do_reset();
    fill(-1, 0);
    send(128, NOPAD, a);
    fill(0, 8'h80);
    send(16, 64'd1024, a);
    chk("R7 rd_addr", a, 0);
    chk("R7 done", done, 1);
    chk("R7 final_len", final_len, 0);
    chk("R7 done_segs", done_segs, 1);
  endtask

  task automatic t_reach_back();
    logic [27:0] a;
    do_reset();
    fill(-1, 0);
    send(64, NOPAD, a);
    buff[0] = 8'h80;
    for (int i = 0; i < 256; i++) if (i != 0) buff[i] = 8'h80;
    // sum 72, msg 52, pad 20 > len 8
    send(8, 64'd416, a);
    chk("R4 pad beyond request no done", done, 0);
    chk("R4 pad beyond request cached", seg_count, 2);
  endtask

  task automatic t_full_hit();
    logic [27:0] a;
    do_reset();
    fill(-1, 0);
    for (int i = 0; i < 16; i++) send(32, NOPAD, a);
    chk("R8 full count", seg_count, 16);
    cache_sel = 4'd15; #1;
    chk("R2 cache_len[15]", cache_len, 32);
    // sum 576, msg 532, pad 44, offset 20
    fill(20, 8'h80);
    send(64, 64'd4256, a);
    chk("R6 done full", done, 1);
    chk("R6 done_segs full", done_segs, 17);
    chk("R6 final_len full", final_len, 20);
    chk("R8 no err on hit", err, 0);
  endtask

  task automatic t_overflow();
    logic [27:0] a;
    do_reset();
    fill(-1, 0);
    for (int i = 0; i < 16; i++) send(32, NOPAD, a);
    send(32, NOPAD, a);
    chk("R8 err", err, 1);
    chk("R8 done low", done, 0);
    chk("R8 count cleared", seg_count, 0);
    chk("R8 total cleared", run_total, 0);
    @(negedge clk);
    chk("R8 err pulse", err, 0);
  endtask

  initial begin
    fill(-1, 0);
    t_reset();
    t_single();
    t_multi();
    t_marker();
    t_big_endian();
    t_too_long();
    t_empty_final();
    t_reach_back();
    t_full_hit();
    t_overflow();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule